// File: doc/BRIEF.md
# Stepwise Output Impedance Code Updater

This block keeps the 8-bit binary code that sets the strength of a driver's output impedance. It moves that code toward a target code that a separate calibration measurement produces. The analog reference and the comparator sit outside the block, so the target arrives as plain digital data. The intended target is an impedance of one fifth of the external reference resistor.

The applied code never jumps. At most one least-significant step is taken per update. Updates are allowed only in bus cycles where the data pins carry no read data, which means write cycles and deselect cycles. A prescaler spaces the updates out to one per PRESCALE eligible cycles. With the default setting, a full sweep across all 256 codes fits inside a power-up budget of about 65,000 eligible cycles.

A calibrated flag tells the system that the applied code has settled on the target. The flag is raised once an update interval has passed with the code still equal to the target. It drops as soon as the target drifts more than one step away from the code.

Top module: `impedance_stepper`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, applied_code is 2^(CODE_W-1) (128 for 8 bits) and calibrated is 0.
- R2: cycle_kind is decoded as 2'b00 = deselect, 2'b01 = write, and 2'b10 or 2'b11 = read. A clock edge sampled with a read kind neither changes applied_code nor advances the prescaler.
- R3: An update happens on the clock edge that samples the PRESCALE-th eligible (write or deselect) cycle, counted since reset or since the previous update. Read cycles in between do not restart the count. applied_code changes only after such an update edge.
- R4: At an update edge, applied_code moves exactly one step toward the target_code sampled at that edge: +1 if the target is above the code, -1 if it is below, and no change if the two are equal.
- R5: Between any two consecutive clock edges, applied_code changes by at most one.
- R6: If applied_code already equals target_code at an update edge, calibrated is 1 after that edge.
- R7: After any edge where |target_code - applied_code| > 1, calibrated is 0. A distance of exactly one leaves calibrated unchanged.
- R8: applied_code reaches the end codes 0 and 2^CODE_W-1 exactly and settles there without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_kind | input | 2 | Type of the current bus cycle (00 deselect, 01 write, 1x read) |
| target_code | input | CODE_W | Impedance code from the calibration measurement |
| applied_code | output | CODE_W | Code currently driving the output impedance |
| calibrated | output | 1 | Applied code has settled on the target |

## Verification
The bench runs the block with a prescaler of 4 and drives it with several kinds of traffic:
- A pseudo-random mix of read, write and deselect cycles. This separates a prescaler that counts only eligible cycles from one that counts every clock or restarts after a read.
- Long stretches of reads against a distant target. These show whether the code and the count really freeze.
- Targets at 0 and 255, and a sweep of targets across the whole range. These exercise both stepping directions and the end codes.
- A target that wobbles by one step around the settled code, followed by a jump of two steps. This tells the "exactly one" case of the calibrated flag apart from the "more than one" case.

// File: rtl/imp_pkg.sv
package imp_pkg;

  typedef enum logic [1:0] {
    CYC_DESELECT = 2'b00,
    CYC_WRITE    = 2'b01,
    CYC_READ     = 2'b10,
    CYC_READ_ALT = 2'b11
  } cyc_kind_e;

  // Data pins are quiet (no read data) only for write and deselect.
  function automatic logic kind_is_quiet(logic [1:0] kind);
    return (kind == CYC_DESELECT) || (kind == CYC_WRITE);
  endfunction

endpackage

// File: rtl/imp_cycle_gate.sv
module imp_cycle_gate #(
  parameter int PRESCALE = 254
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cycle_kind,
  output logic                 eligible,
  output logic                 upd_tick,
  output logic [$clog2(PRESCALE > 1 ? PRESCALE : 2)-1:0] pre_cnt
);
  import imp_pkg::*;

  localparam int CNT_W = $clog2(PRESCALE > 1 ? PRESCALE : 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  assign eligible = kind_is_quiet(cycle_kind);

  generate
    if (PRESCALE <= 1) begin : g_every
      assign upd_tick = eligible;
      assign pre_cnt  = '0;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      assign upd_tick = eligible && (cnt_q == LAST);
      assign pre_cnt  = cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (eligible)
          cnt_q <= upd_tick ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/imp_code_reg.sv
module imp_code_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_tick,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] applied_code
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  function automatic logic [CODE_W-1:0] step_toward(
    logic [CODE_W-1:0] cur, logic [CODE_W-1:0] tgt);
    if (tgt > cur)      return cur + 1'b1;
    else if (tgt < cur) return cur - 1'b1;
    else                return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      applied_code <= MID_CODE;
    else if (upd_tick)
      applied_code <= step_toward(applied_code, target_code);
  end
endmodule

// File: rtl/imp_lock_tracker.sv
module imp_lock_tracker #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_tick,
  input  logic [CODE_W-1:0] applied_code,
  input  logic [CODE_W-1:0] target_code,
  output logic              far_off,
  output logic              lock_hit,
  output logic              calibrated
);
  function automatic logic [CODE_W-1:0] code_gap(
    logic [CODE_W-1:0] a, logic [CODE_W-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  assign far_off  = code_gap(applied_code, target_code) > CODE_W'(1);
  assign lock_hit = upd_tick && (applied_code == target_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      calibrated <= 1'b0;
    else if (far_off)
      calibrated <= 1'b0;
    else if (lock_hit)
      calibrated <= 1'b1;
  end
endmodule

// File: rtl/impedance_stepper.sv
module impedance_stepper #(
  parameter int CODE_W   = 8,
  parameter int BUDGET   = 65000,
  parameter int PRESCALE = BUDGET / ((1 << CODE_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cycle_kind,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] applied_code,
  output logic              calibrated
);
  localparam int CNT_W = $clog2(PRESCALE > 1 ? PRESCALE : 2);

  logic             eligible;
  logic             upd_tick;
  logic [CNT_W-1:0] pre_cnt;
  logic             far_off;
  logic             lock_hit;

  imp_cycle_gate #(.PRESCALE(PRESCALE)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_kind (cycle_kind),
    .eligible   (eligible),
    .upd_tick   (upd_tick),
    .pre_cnt    (pre_cnt)
  );

  imp_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_tick     (upd_tick),
    .target_code  (target_code),
    .applied_code (applied_code)
  );

  imp_lock_tracker #(.CODE_W(CODE_W)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_tick     (upd_tick),
    .applied_code (applied_code),
    .target_code  (target_code),
    .far_off      (far_off),
    .lock_hit     (lock_hit),
    .calibrated   (calibrated)
  );
endmodule

// File: rtl/imp_stepper_chk.sv
module imp_stepper_chk #(
  parameter int CODE_W   = 8,
  parameter int PRESCALE = 254
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cycle_kind,
  input logic [CODE_W-1:0] target_code,
  input logic [CODE_W-1:0] applied_code,
  input logic              calibrated,
  input logic              upd_tick,
  input logic              eligible,
  input logic              far_off
);
  // R2
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_kind[1]) |-> $stable(applied_code));

  // R3
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_tick) |-> $stable(applied_code));

  // R3
  tick_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |-> eligible);

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && (applied_code < target_code)) |=> applied_code == $past(applied_code) + 1'b1);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && (applied_code > target_code)) |=> applied_code == $past(applied_code) - 1'b1);

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (applied_code != $past(applied_code)) |->
      (applied_code == $past(applied_code) + 1'b1 || applied_code == $past(applied_code) - 1'b1));

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrated) |-> $past(upd_tick && (applied_code == target_code)));

  // R7
  drift_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_off |=> !calibrated);
endmodule

bind impedance_stepper imp_stepper_chk #(.CODE_W(CODE_W), .PRESCALE(PRESCALE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cycle_kind   (cycle_kind),
  .target_code  (target_code),
  .applied_code (applied_code),
  .calibrated   (calibrated),
  .upd_tick     (upd_tick),
  .eligible     (eligible),
  .far_off      (far_off)
);

// File: tb/test_impedance_stepper.sv
`timescale 1ns/1ps
module test_impedance_stepper;
  localparam int W  = 8;
  localparam int PS = 4;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cycle_kind = 2'b00;
  logic [W-1:0] target_code = '0;
  logic [W-1:0] applied_code;
  logic         calibrated;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Model state, held in plain integers.
  int  m_code = 128;
  int  m_eligible_seen = 0;
  bit  m_cal = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  impedance_stepper #(.CODE_W(W), .PRESCALE(PS)) i_impedance_stepper (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_kind   (cycle_kind),
    .target_code  (target_code),
    .applied_code (applied_code),
    .calibrated   (calibrated)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at the falling edge, let a rising edge pass,
  // then compare at the next falling edge.
  task automatic cyc(input logic [1:0] kind, input int tgt);
    int  prev;
    int  gap;
    bit  quiet;
    bit  upd;
    string code_req;
    cycle_kind  = kind;
    target_code = W'(tgt);
    prev  = m_code;
    quiet = (kind == 2'b00) || (kind == 2'b01);
    upd   = 0;
    if (quiet) begin
      m_eligible_seen = m_eligible_seen + 1;
      if (m_eligible_seen == PS) begin
        upd = 1;
        m_eligible_seen = 0;
      end
    end
    gap = (tgt > prev) ? tgt - prev : prev - tgt;
    if (gap > 1) m_cal = 0;
    else if (upd && gap == 0) m_cal = 1;
    if (upd) m_code = prev + ((tgt > prev) ? 1 : 0) - ((tgt < prev) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    code_req = !quiet ? "R2" : (upd ? "R4" : "R3");
    check(int'(applied_code) == m_code, code_req, applied_code, m_code);
    check((int'(applied_code) - prev) <= 1 && (prev - int'(applied_code)) <= 1,
          "R5", applied_code, prev);
    check(calibrated == m_cal, (gap > 1) ? "R7" : "R6", calibrated, m_cal);
  endtask

  function automatic logic [1:0] next_kind();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[1:0];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int settled;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(applied_code == 8'd128, "R1", applied_code, 128);
    check(calibrated == 1'b0, "R1", calibrated, 0);
    rst_n = 1'b1;
    cycle_kind = 2'b10;
    target_code = 8'd128;
    @(negedge clk);
    check(applied_code == 8'd128, "R1", applied_code, 128);
    check(calibrated == 1'b0, "R1", calibrated, 0);

    // Already on target, writes only: flag rises after one interval (R6).
    for (int i = 0; i < 3 * PS; i++) cyc(2'b01, 128);

    // Long read stretch with a distant target: frozen code (R2).
    for (int i = 0; i < 200; i++) cyc((i % 2) ? 2'b11 : 2'b10, 10);
    check(applied_code == 8'd128, "R2", applied_code, 128);

    // Mixed traffic toward 200 (R3, R4).
    for (int i = 0; i < 1200; i++) cyc(next_kind(), 200);

    // Down to the lower end code with deselects (R8).
    for (int i = 0; i < 1100; i++) cyc(2'b00, 0);
    check(applied_code == 8'd0, "R8", applied_code, 0);
    for (int i = 0; i < 3 * PS; i++) cyc(2'b00, 0);
    check(applied_code == 8'd0, "R8", applied_code, 0);

    // Up to the upper end code with writes (R8).
    for (int i = 0; i < 1100; i++) cyc(2'b01, MAXC);
    check(int'(applied_code) == MAXC, "R8", applied_code, MAXC);
    for (int i = 0; i < 3 * PS; i++) cyc(2'b01, MAXC);
    check(int'(applied_code) == MAXC, "R8", applied_code, MAXC);

    // Sweep of targets with mixed traffic.
    for (int t = 0; t <= MAXC; t += 15) begin
      for (int i = 0; i < 160; i++) cyc(next_kind(), t);
    end

    // Settle on 60, then wobble by one with reads only (R7: distance one keeps the flag).
    for (int i = 0; i < 1500; i++) cyc(next_kind(), 60);
    settled = int'(applied_code);
    for (int i = 0; i < 3 * PS; i++) cyc(2'b01, settled);
    check(calibrated == 1'b1, "R6", calibrated, 1);
    for (int i = 0; i < 20; i++) cyc(2'b10, (i % 2) ? settled + 1 : settled - 1);
    check(calibrated == 1'b1, "R7", calibrated, 1);
    // Jump of two: flag must drop after the very next edge (R7).
    cyc(2'b10, settled + 2);
    check(calibrated == 1'b0, "R7", calibrated, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule